// File: doc/BRIEF.md
# DDR I/Q Receive Unpacker

This block rebuilds complex baseband samples from a narrow double-data-rate receive bus. The bus carries a data word on both edges of the data clock. The pad-level capture is modelled as two words delivered per clock, one for each edge. A frame strobe is sampled on both edges and travels with the data. Each complex sample arrives as four words: the upper halves of I and Q come first, then the lower halves. The block joins these halves into full-width I and Q words and hands them out on per-channel registers with a one-cycle valid pulse and a channel index.

In single-channel mode a frame is one complex sample. In multi-channel mode a frame holds one complete sample per channel, channel 0 first. The frame strobe is high for the first half of a frame and low for the second half. Its rising transition marks where a frame begins, and that point may fall on either edge of the clock. When the frame starts on the falling edge, the block pairs words across a clock boundary, so it recovers from a half-cycle slip without any outside help. Output only flows while frames keep arriving on time. A missing frame edge drops lock until the next one appears.

Top module: `ddr_iq_unpacker`

## Requirements
- R1: Within each clock the word on `rx_rise_word` precedes the word on `rx_fall_word` in stream order, and `frame_rise`/`frame_fall` are the strobe values of those two words.
- R2: Four consecutive stream words w0..w3 of one complex sample produce I = {w0, w2} and Q = {w1, w3}, with w0 and w1 the upper halves (bits 11:6) and w2 and w3 the lower halves (bits 5:0).
- R3: With `mode_multi` = 0, a frame of four words whose strobe reads 1,1,0,0 yields exactly one sample, and `smp_chan` is 0.
- R4: With `mode_multi` = 1, a frame of 8 words whose strobe reads 1,1,1,1,0,0,0,0 yields two samples in order: channel 0 from the first four words, then channel 1.
- R5: A strobe 0-to-1 transition re-aligns the word pairing. If it lands on a falling-edge word, the block pairs each falling word with the next rising word from then on. The one pair that straddles the switch is discarded. A later transition on a rising-edge word restores straight pairing.
- R6: After reset no `smp_valid` pulse occurs until a frame-start transition has been seen.
- R7: If a frame boundary is reached and no frame-start transition arrives, lock is dropped. Nothing is output until the next transition, whatever the data words hold.
- R8: A frame start that arrives while a sample is half assembled discards that partial sample. Samples already completed earlier in the cut-short frame are still output.
- R9: `smp_valid` is a one-cycle pulse per sample. The register of the channel named by `smp_chan` is updated, and the registers of the other channels hold their values. After reset every channel register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock domain, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_multi | input | 1 | 0: one channel per frame, 1: NUM_CH channels per frame |
| rx_rise_word | input | WORD_W | Word captured on the rising data-clock edge |
| rx_fall_word | input | WORD_W | Word captured on the falling data-clock edge |
| frame_rise | input | 1 | Frame strobe captured on the rising edge |
| frame_fall | input | 1 | Frame strobe captured on the falling edge |
| smp_valid | output | 1 | One-cycle pulse: a complex sample was delivered |
| smp_chan | output | CH_W | Channel index of the delivered sample |
| chan_i | output | NUM_CH x 2*WORD_W | Per-channel I registers |
| chan_q | output | NUM_CH x 2*WORD_W | Per-channel Q registers |

## Verification
The collision that matters is a frame-start realignment and the completion of a sample falling on the same word pair. If the realignment were lost, a new frame's upper halves would be joined with stale data, or a half-built sample would leak out. The bench provokes this with cut-short frames. One multi-channel frame stops after six words, so a new frame edge lands exactly where channel 1 would complete. One single-channel frame stops after three words, so the new edge also lands on a falling-edge word and forces a pairing slip. The scoreboard expects the complete channel-0 sample of the cut frame, nothing for the cut-off part, and every sample of the following frames in order. Any extra or missing pulse is reported.

// File: rtl/ddr_unpack_pkg.sv
package ddr_unpack_pkg;

  // Which half of a complex sample the next word pair carries.
  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_e;

endpackage

// File: rtl/ddr_word_aligner.sv
// Turns the per-clock (rise, fall) word pair into an aligned pair stream.
// A frame start seen on a falling-edge word switches to cross-clock pairing.
module ddr_word_aligner #(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] rise_word,
  input  logic [WORD_W-1:0] fall_word,
  input  logic              rise_strb,
  input  logic              fall_strb,
  output logic              pr_valid,
  output logic [WORD_W-1:0] pr_first,
  output logic [WORD_W-1:0] pr_second,
  output logic              pr_sof,
  output logic              slip_o
);

  logic [WORD_W-1:0] held_word;
  logic              held_strb;
  logic              slip_q;
  logic              late_sof_q;
  logic              start_on_rise;
  logic              start_on_fall;
  logic              slip_now;

  // Strobe 0->1 between the previous falling word and this rising word.
  assign start_on_rise = rise_strb & ~held_strb;
  // Strobe 0->1 between this rising word and this falling word.
  assign start_on_fall = fall_strb & ~rise_strb;
  assign slip_now      = start_on_rise ? 1'b0 : slip_q;
  assign slip_o        = slip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_word  <= '0;
      held_strb  <= 1'b0;
      slip_q     <= 1'b0;
      late_sof_q <= 1'b0;
      pr_valid   <= 1'b0;
      pr_first   <= '0;
      pr_second  <= '0;
      pr_sof     <= 1'b0;
    end else begin
      held_word  <= fall_word;
      held_strb  <= fall_strb;
      late_sof_q <= start_on_fall;
      if (start_on_fall) begin
        slip_q <= 1'b1;
      end else if (start_on_rise) begin
        slip_q <= 1'b0;
      end
      // The pair straddling a switch into slipped pairing is dropped.
      pr_valid <= ~(start_on_fall & ~slip_now);
      if (slip_now) begin
        pr_first  <= held_word;
        pr_second <= rise_word;
        pr_sof    <= late_sof_q;
      end else begin
        pr_first  <= rise_word;
        pr_second <= fall_word;
        pr_sof    <= start_on_rise;
      end
    end
  end

endmodule

// File: rtl/ddr_sample_assembler.sv
// Joins upper/lower word pairs into full I/Q samples and tracks the channel.
module ddr_sample_assembler
  import ddr_unpack_pkg::*;
#(
  parameter int WORD_W = 6,
  parameter int NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SAMP_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_multi,
  input  logic              pr_valid,
  input  logic [WORD_W-1:0] pr_first,
  input  logic [WORD_W-1:0] pr_second,
  input  logic              pr_sof,
  output logic              sa_valid,
  output logic [CH_W-1:0]   sa_chan,
  output logic [SAMP_W-1:0] sa_i,
  output logic [SAMP_W-1:0] sa_q,
  output logic              locked_o
);

  half_e             half_q;
  logic [CH_W-1:0]   chan_q;
  logic              locked_q;
  logic [WORD_W-1:0] i_upper;
  logic [WORD_W-1:0] q_upper;
  logic              last_chan;

  assign last_chan = ~mode_multi | (chan_q == CH_W'(NUM_CH - 1));
  assign locked_o  = locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q   <= HALF_UPPER;
      chan_q   <= '0;
      locked_q <= 1'b0;
      i_upper  <= '0;
      q_upper  <= '0;
      sa_valid <= 1'b0;
      sa_chan  <= '0;
      sa_i     <= '0;
      sa_q     <= '0;
    end else begin
      sa_valid <= 1'b0;
      if (pr_valid) begin
        if (pr_sof) begin
          // Frame start: this pair is channel 0, upper halves.
          locked_q <= 1'b1;
          i_upper  <= pr_first;
          q_upper  <= pr_second;
          half_q   <= HALF_LOWER;
          chan_q   <= '0;
        end else if (locked_q) begin
          if (half_q == HALF_UPPER) begin
            if (chan_q == '0) begin
              // Frame boundary reached without a frame start.
              locked_q <= 1'b0;
            end else begin
              i_upper <= pr_first;
              q_upper <= pr_second;
              half_q  <= HALF_LOWER;
            end
          end else begin
            sa_valid <= 1'b1;
            sa_chan  <= chan_q;
            sa_i     <= {i_upper, pr_first};
            sa_q     <= {q_upper, pr_second};
            half_q   <= HALF_UPPER;
            chan_q   <= last_chan ? '0 : chan_q + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/ddr_sample_outreg.sv
// Registered per-channel output holding registers and the valid pulse.
module ddr_sample_outreg #(
  parameter int SAMP_W = 12,
  parameter int NUM_CH = 2,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           sa_valid,
  input  logic [CH_W-1:0]                sa_chan,
  input  logic [SAMP_W-1:0]              sa_i,
  input  logic [SAMP_W-1:0]              sa_q,
  output logic                           smp_valid,
  output logic [CH_W-1:0]                smp_chan,
  output logic [NUM_CH-1:0][SAMP_W-1:0]  chan_i,
  output logic [NUM_CH-1:0][SAMP_W-1:0]  chan_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_valid <= 1'b0;
      smp_chan  <= '0;
    end else begin
      smp_valid <= sa_valid;
      if (sa_valid) begin
        smp_chan <= sa_chan;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        chan_i[c] <= '0;
        chan_q[c] <= '0;
      end else if (sa_valid && (sa_chan == CH_W'(c))) begin
        chan_i[c] <= sa_i;
        chan_q[c] <= sa_q;
      end
    end
  end

endmodule

// File: rtl/ddr_iq_unpacker.sv
module ddr_iq_unpacker #(
  parameter int WORD_W = 6,
  parameter int NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SAMP_W = 2 * WORD_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode_multi,
  input  logic [WORD_W-1:0]             rx_rise_word,
  input  logic [WORD_W-1:0]             rx_fall_word,
  input  logic                          frame_rise,
  input  logic                          frame_fall,
  output logic                          smp_valid,
  output logic [CH_W-1:0]               smp_chan,
  output logic [NUM_CH-1:0][SAMP_W-1:0] chan_i,
  output logic [NUM_CH-1:0][SAMP_W-1:0] chan_q
);

  logic              pr_valid;
  logic [WORD_W-1:0] pr_first;
  logic [WORD_W-1:0] pr_second;
  logic              pr_sof;
  logic              slip;
  logic              sa_valid;
  logic [CH_W-1:0]   sa_chan;
  logic [SAMP_W-1:0] sa_i;
  logic [SAMP_W-1:0] sa_q;
  logic              locked;

  ddr_word_aligner #(.WORD_W(WORD_W)) u_align (
    .clk       (clk),
    .rst       (rst),
    .rise_word (rx_rise_word),
    .fall_word (rx_fall_word),
    .rise_strb (frame_rise),
    .fall_strb (frame_fall),
    .pr_valid  (pr_valid),
    .pr_first  (pr_first),
    .pr_second (pr_second),
    .pr_sof    (pr_sof),
    .slip_o    (slip)
  );

  ddr_sample_assembler #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) u_asm (
    .clk        (clk),
    .rst        (rst),
    .mode_multi (mode_multi),
    .pr_valid   (pr_valid),
    .pr_first   (pr_first),
    .pr_second  (pr_second),
    .pr_sof     (pr_sof),
    .sa_valid   (sa_valid),
    .sa_chan    (sa_chan),
    .sa_i       (sa_i),
    .sa_q       (sa_q),
    .locked_o   (locked)
  );

  ddr_sample_outreg #(.SAMP_W(SAMP_W), .NUM_CH(NUM_CH)) u_out (
    .clk       (clk),
    .rst       (rst),
    .sa_valid  (sa_valid),
    .sa_chan   (sa_chan),
    .sa_i      (sa_i),
    .sa_q      (sa_q),
    .smp_valid (smp_valid),
    .smp_chan  (smp_chan),
    .chan_i    (chan_i),
    .chan_q    (chan_q)
  );

endmodule

// File: rtl/ddr_iq_unpacker_chk.sv
module ddr_iq_unpacker_chk #(
  parameter int CH_W = 1
) (
  input logic            clk,
  input logic            rst,
  input logic            mode_multi,
  input logic            frame_rise,
  input logic            frame_fall,
  input logic            slip,
  input logic            pr_valid,
  input logic            pr_sof,
  input logic            locked,
  input logic            sa_valid,
  input logic            smp_valid,
  input logic [CH_W-1:0] smp_chan
);

  // R5
  slip_entry_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_fall && !frame_rise && !slip) |=> !pr_valid);

  // R6
  lock_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(pr_valid && pr_sof));

  // R7
  unlock_needs_plain_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(pr_valid && !pr_sof));

  // R9
  valid_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> !smp_valid);

  // R9
  valid_from_assembly_chk: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $past(sa_valid));

  // R3
  single_mode_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !$past(mode_multi, 2)) |-> (smp_chan == '0));

endmodule

bind ddr_iq_unpacker ddr_iq_unpacker_chk #(.CH_W(CH_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .mode_multi (mode_multi),
  .frame_rise (frame_rise),
  .frame_fall (frame_fall),
  .slip       (slip),
  .pr_valid   (pr_valid),
  .pr_sof     (pr_sof),
  .locked     (locked),
  .sa_valid   (sa_valid),
  .smp_valid  (smp_valid),
  .smp_chan   (smp_chan)
);

// File: tb/ddr_iq_unpacker_tb_top.sv
module ddr_iq_unpacker_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 6;
  localparam int NUM_CH     = 2;
  localparam int SAMP_W     = 2 * WORD_W;
  localparam int WDOG_LIMIT = 100000;

  typedef struct packed {
    logic [WORD_W-1:0] w;
    logic              f;
  } wd_t;

  typedef struct packed {
    logic              ch;
    logic [SAMP_W-1:0] i;
    logic [SAMP_W-1:0] q;
  } ex_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_multi = 1'b0;
  logic [WORD_W-1:0] rx_rise_word = '0;
  logic [WORD_W-1:0] rx_fall_word = '0;
  logic frame_rise = 1'b0;
  logic frame_fall = 1'b0;
  logic smp_valid;
  logic smp_chan;
  logic [NUM_CH-1:0][SAMP_W-1:0] chan_i;
  logic [NUM_CH-1:0][SAMP_W-1:0] chan_q;

  wd_t wq[$];
  ex_t eq[$];
  logic [SAMP_W-1:0] sh_i [NUM_CH];
  logic [SAMP_W-1:0] sh_q [NUM_CH];
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_iq_unpacker #(.WORD_W(WORD_W), .NUM_CH(NUM_CH)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .mode_multi   (mode_multi),
    .rx_rise_word (rx_rise_word),
    .rx_fall_word (rx_fall_word),
    .frame_rise   (frame_rise),
    .frame_fall   (frame_fall),
    .smp_valid    (smp_valid),
    .smp_chan     (smp_chan),
    .chan_i       (chan_i),
    .chan_q       (chan_q)
  );

  // Driver: two stream words per clock, rising-edge word first (R1).
  always @(negedge clk) begin
    wd_t a;
    wd_t b;
    a = '0;
    b = '0;
    if (!rst && wq.size() > 0) a = wq.pop_front();
    if (!rst && wq.size() > 0) b = wq.pop_front();
    rx_rise_word = a.w;
    frame_rise   = a.f;
    rx_fall_word = b.w;
    frame_fall   = b.f;
  end

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst && smp_valid) begin
      checks++;
      if (eq.size() == 0) begin
        failures++;
        $display("FAIL R6/R7/R8: unexpected sample ch=%0d i=%h q=%h, expected none",
                 smp_chan, chan_i[smp_chan], chan_q[smp_chan]);
      end else begin
        ex_t e;
        e = eq.pop_front();
        sh_i[e.ch] = e.i;
        sh_q[e.ch] = e.q;
        if (smp_chan !== e.ch || chan_i[0] !== sh_i[0] || chan_q[0] !== sh_q[0] ||
            chan_i[1] !== sh_i[1] || chan_q[1] !== sh_q[1]) begin
          failures++;
          $display("FAIL R2/R4/R9: ch=%0d i0=%h q0=%h i1=%h q1=%h, expected ch=%0d i0=%h q0=%h i1=%h q1=%h",
                   smp_chan, chan_i[0], chan_q[0], chan_i[1], chan_q[1],
                   e.ch, sh_i[0], sh_q[0], sh_i[1], sh_q[1]);
        end
      end
    end
  end

  // Watchdog.
  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIMIT && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cycles, WDOG_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic push_w(input logic [WORD_W-1:0] w, input logic f);
    wd_t x;
    x.w = w;
    x.f = f;
    wq.push_back(x);
  endtask

  task automatic junk(input int n, input logic f, input logic [WORD_W-1:0] seed);
    for (int k = 0; k < n; k++) push_w(seed ^ WORD_W'(k * 13), f);
  endtask

  task automatic expect_s(input logic ch, input logic [SAMP_W-1:0] i, input logic [SAMP_W-1:0] q);
    ex_t e;
    e.ch = ch;
    e.i  = i;
    e.q  = q;
    eq.push_back(e);
  endtask

  // R2 word order inside one complex sample: I upper, Q upper, I lower, Q lower.
  task automatic sample_words(input logic [SAMP_W-1:0] i, input logic [SAMP_W-1:0] q,
                              input logic f_hi, input logic f_lo);
    push_w(i[SAMP_W-1:WORD_W], f_hi);
    push_w(q[SAMP_W-1:WORD_W], f_hi);
    push_w(i[WORD_W-1:0], f_lo);
    push_w(q[WORD_W-1:0], f_lo);
  endtask

  // R3 single-channel frame.
  task automatic single_frame(input logic [SAMP_W-1:0] i, input logic [SAMP_W-1:0] q);
    sample_words(i, q, 1'b1, 1'b0);
    expect_s(1'b0, i, q);
  endtask

  // R4 multi-channel frame.
  task automatic multi_frame(input logic [SAMP_W-1:0] i0, input logic [SAMP_W-1:0] q0,
                             input logic [SAMP_W-1:0] i1, input logic [SAMP_W-1:0] q1);
    sample_words(i0, q0, 1'b1, 1'b1);
    sample_words(i1, q1, 1'b0, 1'b0);
    expect_s(1'b0, i0, q0);
    expect_s(1'b1, i1, q1);
  endtask

  task automatic drain(input string tag);
    wait (wq.size() == 0);
    repeat (8) @(negedge clk);
    checks++;
    if (eq.size() != 0) begin
      failures++;
      $display("FAIL %s: samples missing, actual pending=%0d expected 0", tag, eq.size());
      eq.delete();
    end
  endtask

  initial begin
    for (int c = 0; c < NUM_CH; c++) begin
      sh_i[c] = '0;
      sh_q[c] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    checks++;
    if (smp_valid !== 1'b0 || chan_i !== '0 || chan_q !== '0) begin
      failures++;
      $display("FAIL R9: reset state valid=%b i=%h q=%h, expected 0 0 0", smp_valid, chan_i, chan_q);
    end

    // R6: data with the strobe held low gives no sample.
    junk(10, 1'b0, 6'h2b);
    drain("R6");

    // R2, R3: straight single-channel frames.
    mode_multi = 1'b0;
    single_frame(12'hA5C, 12'h3F1);
    single_frame(12'h001, 12'hFFE);
    single_frame(12'h7E3, 12'h81C);
    drain("R3");

    // R7: frame boundary passes without a strobe edge, lock drops.
    single_frame(12'h123, 12'h456);
    junk(8, 1'b0, 6'h15);
    single_frame(12'hBCD, 12'hE0F);
    drain("R7");

    // R4: multi-channel frames, channel 0 then channel 1.
    mode_multi = 1'b1;
    multi_frame(12'h111, 12'h222, 12'h333, 12'h444);
    multi_frame(12'hFED, 12'hCBA, 12'h987, 12'h654);
    drain("R4");

    // R8: multi frame cut after six words; ch0 kept, ch1 lost.
    sample_words(12'h5A5, 12'hA5A, 1'b1, 1'b1);
    push_w(6'h3C, 1'b0);
    push_w(6'h0F, 1'b0);
    expect_s(1'b0, 12'h5A5, 12'hA5A);
    multi_frame(12'h0C3, 12'h30C, 12'hC30, 12'h03C);
    drain("R8");

    // R5: odd word offset, frames start on falling-edge words.
    mode_multi = 1'b0;
    junk(3, 1'b0, 6'h2e);
    single_frame(12'h9A1, 12'h1B2);
    single_frame(12'h2C3, 12'h3D4);
    single_frame(12'h4E5, 12'h5F6);
    drain("R5");

    // R5: back to rising-edge frame starts after the slip.
    single_frame(12'h6A7, 12'h7B8);
    single_frame(12'h8C9, 12'h9DA);
    drain("R5");

    // R8, R5: single frame cut after three words, new frame on a falling word.
    push_w(6'h11, 1'b1);
    push_w(6'h22, 1'b1);
    push_w(6'h33, 1'b0);
    single_frame(12'hAB0, 12'hCD1);
    single_frame(12'hEF2, 12'h013);
    drain("R8");

    // R5, R4: multi-channel frames on a falling-edge offset.
    mode_multi = 1'b1;
    junk(1, 1'b0, 6'h07);
    multi_frame(12'h1E1, 12'h2D2, 12'h3C3, 12'h4B4);
    multi_frame(12'h5A5, 12'h696, 12'h787, 12'h878);
    drain("R4");

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule